// File: doc/BRIEF.md
# Floating-Point Compare-to-Status-Bit Unit

This block compares two IEEE-754 operands, either both single precision or both double precision as chosen per operation. It evaluates one of six ordering relations and stores the outcome as a single registered status bit. The result is 1 when the relation holds and 0 when it does not. A second registered output reports that the last comparison was unordered because at least one operand was a NaN.

Each operand arrives on a 64-bit bus made of a register pair. Bits [63:32] come from the even-numbered register and bits [31:0] from the odd register that follows it. A double-precision value spans the whole pair, with its upper half in the even register. A single-precision value occupies only the even register. The unit takes no action unless the valid strobe is high, and both outputs change on the clock edge that samples that strobe.

Top module: `fp_cmp_flag`

## Requirements
- R1: After reset both `fsr_bit` and `unord_flag` are 0.
- R2: When `op_valid` is high at a rising edge, both outputs take the new result at that edge. When `op_valid` is low, both outputs keep their values.
- R3: The relation codes are 0 for less-than, 1 for greater-than, 2 for less-or-equal, 3 for greater-or-equal, 4 for equal and 5 for not-equal, where the relation is read as "a rel b". `fsr_bit` becomes 1 when the relation holds and 0 when it does not.
- R4: Relation codes 6 and 7 always give `fsr_bit` = 0, whether the operands are ordered or unordered.
- R5: When `dbl_sel` = 0, each operand is the single-precision value in bits [63:32]. Bits [31:0] have no effect on the result.
- R6: When `dbl_sel` = 1, each operand is the double-precision value formed as {even register [63:32], odd register [31:0]}. A difference confined to the odd register changes the result.
- R7: +0 and -0 compare as equal in both precisions.
- R8: If either operand is a NaN (exponent all ones, fraction nonzero), every relation gives 0 except not-equal, which gives 1.
- R9: `unord_flag` becomes 1 on a valid comparison that involves a NaN and 0 on a valid comparison of two ordered operands.
- R10: Negative values are ordered correctly: between two negatives, the one with the larger magnitude is the smaller value. Infinities order beyond every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Strobe that starts a comparison |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| rel_code | input | 3 | Relation to evaluate |
| src_a | input | 64 | Left operand register pair |
| src_b | input | 64 | Right operand register pair |
| fsr_bit | output | 1 | Registered status bit holding the comparison result |
| unord_flag | output | 1 | Registered flag set when the last comparison was unordered |

## Verification
Pairs of positive values, of mixed signs and of two negatives are each run through all six relations. These cases separate a correct sign-magnitude ordering from one that skips the inversion for negatives or mishandles mixed signs. Signed zeros and NaN operands check the special cases. Operand pairs that differ only in the odd register are run in both precisions, which shows that the precision select picks the correct bits. Cycles with the strobe low and changed inputs confirm that both outputs hold, and the unused relation codes confirm a constant zero.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 2 * WORD_W;
    localparam int DEXP_W = 11;
    localparam int DFRC_W = 52;
    localparam int SEXP_W = 8;
    localparam int SFRC_W = 23;
    localparam int MAG_W  = DEXP_W + DFRC_W;

    typedef enum logic [2:0] {
        REL_LT = 3'd0,
        REL_GT = 3'd1,
        REL_LE = 3'd2,
        REL_GE = 3'd3,
        REL_EQ = 3'd4,
        REL_NE = 3'd5
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_nan;
        logic             is_zero;
    } fp_key_t;

    typedef struct packed {
        logic fsr;
        logic unord;
    } cmp_state_t;
endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
(
    input  logic [BUS_W-1:0] pair,
    input  logic             dbl,
    output fp_key_t          key
);
    localparam int EXP_PAD = DEXP_W - SEXP_W;
    localparam int FRC_PAD = DFRC_W - SFRC_W;

    logic [WORD_W-1:0] even_w;
    logic              s_sign, d_sign;
    logic [SEXP_W-1:0] s_exp;
    logic [SFRC_W-1:0] s_frc;
    logic [DEXP_W-1:0] d_exp;
    logic [DFRC_W-1:0] d_frc;

    always_comb begin
        even_w = pair[BUS_W-1:WORD_W];
        {s_sign, s_exp, s_frc} = even_w;
        {d_sign, d_exp, d_frc} = pair;
        if (dbl) begin
            key.sign   = d_sign;
            key.mag    = {d_exp, d_frc};
            key.is_nan = (&d_exp) && (|d_frc);
        end else begin
            key.sign   = s_sign;
            key.mag    = {{EXP_PAD{1'b0}}, s_exp, s_frc, {FRC_PAD{1'b0}}};
            key.is_nan = (&s_exp) && (|s_frc);
        end
        key.is_zero = (key.mag == '0);
    end
endmodule

// File: rtl/fpc_order.sv
module fpc_order
    import fpc_pkg::*;
(
    input  fp_key_t ka,
    input  fp_key_t kb,
    output logic    a_lt,
    output logic    a_gt,
    output logic    a_eq,
    output logic    unord
);
    logic mag_lt, mag_gt, mag_eq, both_zero;

    always_comb begin
        unord     = ka.is_nan | kb.is_nan;
        both_zero = ka.is_zero & kb.is_zero;
        mag_lt    = ka.mag < kb.mag;
        mag_gt    = ka.mag > kb.mag;
        mag_eq    = ka.mag == kb.mag;
        a_lt = 1'b0;
        a_gt = 1'b0;
        a_eq = 1'b0;
        if (!unord) begin
            if (both_zero) begin
                a_eq = 1'b1;
            end else if (ka.sign != kb.sign) begin
                a_lt = ka.sign;
                a_gt = kb.sign;
            end else if (ka.sign) begin
                a_lt = mag_gt;
                a_gt = mag_lt;
                a_eq = mag_eq;
            end else begin
                a_lt = mag_lt;
                a_gt = mag_gt;
                a_eq = mag_eq;
            end
        end
    end
endmodule

// File: rtl/fp_cmp_flag.sv
module fp_cmp_flag
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             dbl_sel,
    input  logic [2:0]       rel_code,
    input  logic [BUS_W-1:0] src_a,
    input  logic [BUS_W-1:0] src_b,
    output logic             fsr_bit,
    output logic             unord_flag
);
    localparam int NOPS = 2;

    fp_key_t    keys [NOPS];
    logic [BUS_W-1:0] srcs [NOPS];
    logic       lt_w, gt_w, eq_w, un_w, hit_w;
    cmp_state_t st_d, st_q;

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
        fpc_unpack u_unpack (.pair(srcs[gi]), .dbl(dbl_sel), .key(keys[gi]));
    end

    fpc_order u_order (
        .ka(keys[0]), .kb(keys[1]),
        .a_lt(lt_w), .a_gt(gt_w), .a_eq(eq_w), .unord(un_w)
    );

    always_comb begin
        case (rel_code)
            REL_LT:  hit_w = lt_w;
            REL_GT:  hit_w = gt_w;
            REL_LE:  hit_w = lt_w | eq_w;
            REL_GE:  hit_w = gt_w | eq_w;
            REL_EQ:  hit_w = eq_w;
            REL_NE:  hit_w = ~eq_w;
            default: hit_w = 1'b0;
        endcase
        st_d = st_q;
        if (op_valid) begin
            st_d.fsr   = hit_w;
            st_d.unord = un_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fsr_bit    = st_q.fsr;
    assign unord_flag = st_q.unord;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(fsr_bit) && $stable(unord_flag)));
    // R9
    nan_sets_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (keys[0].is_nan || keys[1].is_nan)) |=> unord_flag);
    // R8
    nan_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && un_w && rel_code != REL_NE) |=> !fsr_bit);
    // R7
    zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && keys[0].is_zero && keys[1].is_zero && rel_code == REL_EQ) |=> fsr_bit);
    // R3
    order_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lt_w, gt_w, eq_w}));
    // R4
    spare_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rel_code > 3'd5) |=> !fsr_bit);
endmodule

// File: tb/fp_cmp_flag_tb_top.sv
`timescale 1ns/1ps
module fp_cmp_flag_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        dbl_sel = 1'b0;
    logic [2:0]  rel_code = 3'd0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        fsr_bit, unord_flag;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fp_cmp_flag dut_i (.*);

    localparam logic [63:0] S_ONE  = 64'h3F800000_00000000;
    localparam logic [63:0] S_TWO  = 64'h40000000_00000000;
    localparam logic [63:0] S_MONE = 64'hBF800000_00000000;
    localparam logic [63:0] S_MTWO = 64'hC0000000_00000000;
    localparam logic [63:0] S_PZ   = 64'h00000000_00000000;
    localparam logic [63:0] S_MZ   = 64'h80000000_00000000;
    localparam logic [63:0] S_NAN  = 64'h7FC00000_00000000;
    localparam logic [63:0] S_INF  = 64'h7F800000_00000000;
    localparam logic [63:0] D_ONE  = 64'h3FF00000_00000000;
    localparam logic [63:0] D_ONEU = 64'h3FF00000_00000001;
    localparam logic [63:0] D_MTHR = 64'hC0080000_00000000;
    localparam logic [63:0] D_MZ   = 64'h80000000_00000000;
    localparam logic [63:0] D_NAN  = 64'h7FF80000_00000000;

    task automatic check(input string req, input logic got, input logic exp_v, input string what);
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp_v);
        end
    endtask

    task automatic do_cmp(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic dbl, input logic [2:0] rel,
                          input logic exp_f, input logic exp_u);
        @(negedge clk);
        src_a = a; src_b = b; dbl_sel = dbl; rel_code = rel; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, fsr_bit, exp_f, $sformatf("fsr a=%h b=%h dbl=%0b rel=%0d", a, b, dbl, rel));
        check(req, unord_flag, exp_u, "unord");
    endtask

    // six relations: pattern bits ordered LT,GT,LE,GE,EQ,NE
    task automatic all_rel(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic dbl, input logic [5:0] pat, input logic u);
        for (int r = 0; r < 6; r++) do_cmp(req, a, b, dbl, 3'(r), pat[5-r], u);
    endtask

    task automatic t_reset;
        check("R1", fsr_bit, 1'b0, "reset fsr");
        check("R1", unord_flag, 1'b0, "reset unord");
    endtask

    task automatic t_positive;   // R3: 1 < 2
        all_rel("R3", S_ONE, S_TWO, 1'b0, 6'b101001, 1'b0);
        all_rel("R3", S_TWO, S_ONE, 1'b0, 6'b010101, 1'b0);
        all_rel("R3", S_TWO, S_TWO, 1'b0, 6'b001110, 1'b0);
    endtask

    task automatic t_negative;   // R10
        all_rel("R10", S_MTWO, S_MONE, 1'b0, 6'b101001, 1'b0);
        all_rel("R10", S_MONE, S_ONE, 1'b0, 6'b101001, 1'b0);
        all_rel("R10", S_INF, S_TWO, 1'b0, 6'b010101, 1'b0);
        all_rel("R10", D_MTHR, D_ONE, 1'b1, 6'b101001, 1'b0);
    endtask

    task automatic t_zero;       // R7
        all_rel("R7", S_PZ, S_MZ, 1'b0, 6'b001110, 1'b0);
        all_rel("R7", D_MZ, S_PZ, 1'b1, 6'b001110, 1'b0);
    endtask

    task automatic t_nan;        // R8 R9
        all_rel("R8", S_NAN, S_ONE, 1'b0, 6'b000001, 1'b1);
        all_rel("R8", D_ONE, D_NAN, 1'b1, 6'b000001, 1'b1);
        do_cmp("R9", S_ONE, S_ONE, 1'b0, 3'd4, 1'b1, 1'b0);
    endtask

    task automatic t_precision;  // R5 R6
        do_cmp("R5", D_ONEU, D_ONE, 1'b0, 3'd4, 1'b1, 1'b0);
        do_cmp("R5", S_ONE | 64'h0000_0000_FFFF_FFFF, S_TWO, 1'b0, 3'd0, 1'b1, 1'b0);
        do_cmp("R6", D_ONEU, D_ONE, 1'b1, 3'd4, 1'b0, 1'b0);
        do_cmp("R6", D_ONE, D_ONEU, 1'b1, 3'd0, 1'b1, 1'b0);
    endtask

    task automatic t_spare;      // R4
        do_cmp("R4", S_ONE, S_ONE, 1'b0, 3'd6, 1'b0, 1'b0);
        do_cmp("R4", S_ONE, S_TWO, 1'b0, 3'd7, 1'b0, 1'b0);
        do_cmp("R4", S_NAN, S_ONE, 1'b0, 3'd7, 1'b0, 1'b1);
    endtask

    task automatic t_hold;       // R2
        do_cmp("R2", S_NAN, S_ONE, 1'b0, 3'd5, 1'b1, 1'b1);
        @(negedge clk);
        src_a = S_ONE; src_b = S_ONE; rel_code = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R2", fsr_bit, 1'b1, "hold fsr");
        check("R2", unord_flag, 1'b1, "hold unord");
        src_a = S_ONE; src_b = S_TWO; rel_code = 3'd0; op_valid = 1'b1;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        check("R2", fsr_bit, 1'b1, "update after one edge");
        check("R2", unord_flag, 1'b0, "unord cleared after one edge");
    endtask

    initial begin
        #1;
        t_reset();
        #20 rst_n = 1'b1;
        t_positive();
        t_negative();
        t_zero();
        t_nan();
        t_precision();
        t_spare();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule